// File: doc/BRIEF.md
# Read Resynchronization Phase Calibration Sequencer

This block runs and judges the read-path calibration of a memory PHY. After reset it waits until the memory controller reports two things: it has finished initialising the memory, and it is ready. The block then takes over the controller's command port. For every resynchronization clock phase, from the lowest index to the highest, it issues one test write and then one test read. On each read acknowledge it samples two values from the memory side: whether the returned data matched, and the read latency at which it matched.

When the last phase has been tested, the block classifies the sweep. The phase axis is linear, not circular. A valid window is a maximal run of adjacent passing phases. The sweep succeeds only if there is exactly one window and the passing phases show at most two distinct latencies. On success the block reports the window's centre phase and the latency recorded at that phase. Any other outcome raises one or more sticky error flags. In both cases calibration-done is raised and the command port is handed back to the user.

Top module: `rsync_cal_eval`

## Requirements
- R1: No memory request is issued until `ctl_init_done_i` and `ctl_ready_i` have been high together in the same cycle; either one alone never starts calibration.
- R2: For each phase index 0 to NPH-1, in rising order, the block issues one write (`mem_wr_o`=1) and then one read (`mem_wr_o`=0), with `phase_o` holding that index. Each request is held until `mem_ack_i`. Only the read acknowledge samples `mem_pass_i` and `mem_lat_i`.
- R3: Until calibration is done, `usr_ack_o` stays 0 and user requests are not forwarded to the memory port.
- R4: A window is a maximal run of consecutive passing phases. Phase NPH-1 and phase 0 are not adjacent. Two or more windows set `err_multi_win_o` to 1.
- R5: If the passing phases show more than two distinct `mem_lat_i` values, `err_multi_lat_o` is set to 1.
- R6: If no phase passes, `err_no_win_o` is set to 1.
- R7: `cal_ok_o` is 1 only when there is exactly one window and at most two distinct latencies. On success, `best_phase_o` = floor((first passing phase + last passing phase)/2) of that window, and `best_lat_o` is the latency sampled at that phase. On failure both outputs are 0.
- R8: After the read of phase NPH-1, `cal_done_o` rises. From then until reset, `cal_done_o`, `cal_ok_o` and all error flags hold their values, whatever the controller status inputs do.
- R9: Once `cal_done_o` is 1, `mem_req_o` follows `usr_req_i`, `mem_wr_o` follows `usr_wr_i`, and `usr_ack_o` follows `mem_ack_i`.
- R10: While `rst_n` is low, every output is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| ctl_init_done_i | input | 1 | Controller has finished memory initialisation |
| ctl_ready_i | input | 1 | Controller is ready for commands |
| usr_req_i | input | 1 | User command request |
| usr_wr_i | input | 1 | User command is a write |
| usr_ack_o | output | 1 | User command acknowledged |
| mem_req_o | output | 1 | Request to the memory command port |
| mem_wr_o | output | 1 | Request is a write (1) or read (0) |
| mem_ack_i | input | 1 | Memory command port acknowledge |
| mem_pass_i | input | 1 | Read data matched (valid with read acknowledge) |
| mem_lat_i | input | LATW | Latency of the matching read |
| phase_o | output | PHW | Resynchronization phase under test |
| cal_done_o | output | 1 | Calibration finished |
| cal_ok_o | output | 1 | Calibration succeeded |
| err_multi_win_o | output | 1 | More than one valid window seen |
| err_multi_lat_o | output | 1 | More than two read latencies seen |
| err_no_win_o | output | 1 | No passing phase seen |
| best_phase_o | output | PHW | Centre phase of the single window |
| best_lat_o | output | LATW | Latency at the centre phase |

## Verification
The assertions check on every cycle that:
- the first request follows a cycle in which both status inputs were high;
- the phase does not move while a write is outstanding, and steps by exactly one after each read acknowledge;
- success excludes every error flag;
- done and the flags never change once set.

Only the bench scenarios can show that the classification is right. These scenarios cover:
- windows touching either end of the phase range;
- a fully passing sweep and an empty sweep;
- split windows;
- latency spreads of two versus three values;
- the centre-phase arithmetic for even and odd window widths.

They also show the return of the port to the user.

// File: rtl/rsync_cal_eval.sv
module rsync_cal_eval #(
  parameter int NPH  = 8,
  parameter int LATW = 3,
  localparam int PHW = (NPH > 1) ? $clog2(NPH) : 1,
  localparam int NLAT = 1 << LATW
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            ctl_init_done_i,
  input  logic            ctl_ready_i,
  input  logic            usr_req_i,
  input  logic            usr_wr_i,
  output logic            usr_ack_o,
  output logic            mem_req_o,
  output logic            mem_wr_o,
  input  logic            mem_ack_i,
  input  logic            mem_pass_i,
  input  logic [LATW-1:0] mem_lat_i,
  output logic [PHW-1:0]  phase_o,
  output logic            cal_done_o,
  output logic            cal_ok_o,
  output logic            err_multi_win_o,
  output logic            err_multi_lat_o,
  output logic            err_no_win_o,
  output logic [PHW-1:0]  best_phase_o,
  output logic [LATW-1:0] best_lat_o
);

  typedef enum logic [2:0] {S_IDLE, S_WR, S_RD, S_FIN, S_DONE} st_t;

  st_t             st;
  logic [PHW-1:0]  ph, wstart, wend;
  logic            prev_pass;
  logic [1:0]      nwin;
  logic [NLAT-1:0] lat_seen;
  logic [LATW-1:0] lat_q [NPH];
  logic [PHW:0]    wsum;
  logic [PHW-1:0]  center;
  logic            many_lat;

  assign wsum     = {1'b0, wstart} + {1'b0, wend};
  assign center   = wsum[PHW:1];
  assign many_lat = $countones(lat_seen) > 2;

  assign phase_o   = ph;
  assign mem_req_o = cal_done_o ? usr_req_i : (st == S_WR || st == S_RD);
  assign mem_wr_o  = cal_done_o ? usr_wr_i  : (st == S_WR);
  assign usr_ack_o = cal_done_o & mem_ack_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE;
      ph <= '0;
      wstart <= '0;
      wend <= '0;
      prev_pass <= 1'b0;
      nwin <= '0;
      lat_seen <= '0;
      for (int i = 0; i < NPH; i++) lat_q[i] <= '0;
      cal_done_o <= 1'b0;
      cal_ok_o <= 1'b0;
      err_multi_win_o <= 1'b0;
      err_multi_lat_o <= 1'b0;
      err_no_win_o <= 1'b0;
      best_phase_o <= '0;
      best_lat_o <= '0;
    end else begin
      case (st)
        S_IDLE: if (ctl_init_done_i && ctl_ready_i) begin
          st <= S_WR;
          ph <= '0;
          prev_pass <= 1'b0;
          nwin <= '0;
          lat_seen <= '0;
        end
        S_WR: if (mem_ack_i) st <= S_RD;
        S_RD: if (mem_ack_i) begin
          prev_pass <= mem_pass_i;
          lat_q[ph] <= mem_lat_i;
          if (mem_pass_i) begin
            lat_seen[mem_lat_i] <= 1'b1;
            if (!prev_pass) begin
              if (nwin == 2'd0) begin
                wstart <= ph;
                wend <= ph;
              end
              if (nwin != 2'd2) nwin <= nwin + 2'd1;
            end else if (nwin == 2'd1) begin
              wend <= ph;
            end
          end
          if (ph == PHW'(NPH - 1)) st <= S_FIN;
          else begin
            ph <= ph + 1'b1;
            st <= S_WR;
          end
        end
        S_FIN: begin
          st <= S_DONE;
          cal_done_o <= 1'b1;
          err_multi_win_o <= (nwin == 2'd2);
          err_multi_lat_o <= many_lat;
          err_no_win_o <= (nwin == 2'd0);
          if (nwin == 2'd1 && !many_lat) begin
            cal_ok_o <= 1'b1;
            best_phase_o <= center;
            best_lat_o <= lat_q[center];
          end
        end
        default: st <= S_DONE;
      endcase
    end
  end

  AST_START_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_req_o) && !cal_done_o |-> $past(ctl_init_done_i && ctl_ready_i)); // R1
  AST_PHASE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_WR) |=> $stable(phase_o)); // R2
  AST_PHASE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_RD && mem_ack_i) |=> (st == S_FIN) || (phase_o == PHW'($past(phase_o) + 1'b1))); // R2
  AST_OK_CLEAN: assert property (@(posedge clk) disable iff (!rst_n)
    cal_ok_o |-> cal_done_o && !err_multi_win_o && !err_multi_lat_o && !err_no_win_o); // R7
  AST_DONE_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    cal_done_o |=> cal_done_o && $stable(cal_ok_o) && $stable(err_multi_win_o)
                   && $stable(err_multi_lat_o) && $stable(err_no_win_o)); // R8
  AST_FLAG_NEEDS_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    (err_multi_win_o || err_multi_lat_o || err_no_win_o) |-> cal_done_o); // R8

endmodule

// File: tb/sim_rsync_cal_eval.sv
module sim_rsync_cal_eval;
  localparam int NPH = 8;
  localparam int LATW = 3;
  localparam int PHW = 3;
  localparam int CLK_PERIOD = 10;

  logic clk = 0, rst_n = 0;
  logic ctl_init_done_i = 0, ctl_ready_i = 0, usr_req_i = 0, usr_wr_i = 0;
  logic mem_ack_i = 0, mem_pass_i = 0;
  logic [LATW-1:0] mem_lat_i = '0;
  logic usr_ack_o, mem_req_o, mem_wr_o, cal_done_o, cal_ok_o;
  logic err_multi_win_o, err_multi_lat_o, err_no_win_o;
  logic [PHW-1:0] phase_o, best_phase_o;
  logic [LATW-1:0] best_lat_o;

  rsync_cal_eval #(.NPH(NPH), .LATW(LATW)) u0 (.*);

  always #(CLK_PERIOD/2) clk = ~clk;

  int total = 0, bad = 0, cyc = 0;
  bit tp [NPH];
  logic [LATW-1:0] tl [NPH];
  int ord_bad, rd_idx, last_wr;
  bit wr_seen;

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      bad++; total++;
      $display("FAIL watchdog act=%0d exp=%0d", cyc, 150000);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  always @(negedge clk) begin
    if (mem_ack_i) begin
      mem_ack_i = 0; mem_pass_i = 0;
    end else if (mem_req_o) begin
      mem_ack_i = 1;
      mem_pass_i = 0;
      if (!cal_done_o) begin
        if (mem_wr_o) begin
          last_wr = int'(phase_o); wr_seen = 1;
        end else begin
          if (!wr_seen || last_wr != int'(phase_o) || rd_idx != int'(phase_o)) ord_bad++;
          mem_pass_i = tp[phase_o];
          mem_lat_i = tl[phase_o];
          rd_idx++; wr_seen = 0;
        end
      end
    end
  end

  task automatic chk(bit ok, string req, int act, int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%0d exp=%0d", req, act, exp);
    end
  endtask

  int e_nw, e_fs, e_ls, e_nl, e_ctr, e_lat;
  bit e_ok;

  task automatic calc_exp();
    bit prev = 0;
    bit [7:0] mask = 0;
    e_nw = 0; e_fs = 0; e_ls = 0;
    for (int p = 0; p < NPH; p++) begin
      if (tp[p]) begin
        if (!prev) begin
          e_nw++;
          if (e_nw == 1) e_fs = p;
        end
        if (e_nw == 1) e_ls = p;
        mask[tl[p]] = 1;
      end
      prev = tp[p];
    end
    e_nl = $countones(mask);
    e_ok = (e_nw == 1) && (e_nl <= 2);
    e_ctr = e_ok ? (e_fs + e_ls) / 2 : 0;
    e_lat = e_ok ? int'(tl[e_ctr]) : 0;
  endtask

  task automatic run();
    int early = 0, leak = 0, seen = 0;
    calc_exp();
    rst_n = 0; ctl_init_done_i = 0; ctl_ready_i = 0; usr_req_i = 1; usr_wr_i = 1;
    ord_bad = 0; rd_idx = 0; wr_seen = 0; last_wr = -1;
    repeat (3) @(posedge clk);
    #2;
    chk(!(cal_done_o | cal_ok_o | err_multi_win_o | err_multi_lat_o | err_no_win_o | mem_req_o | usr_ack_o)
        && phase_o == 0 && best_phase_o == 0 && best_lat_o == 0, "R10 reset", int'(mem_req_o), 0);
    rst_n = 1; ctl_init_done_i = 1;
    repeat (4) begin @(posedge clk); #2; if (mem_req_o) early++; end
    ctl_init_done_i = 0; ctl_ready_i = 1;
    repeat (4) begin @(posedge clk); #2; if (mem_req_o) early++; end
    chk(early == 0, "R1 start gated", early, 0);
    ctl_init_done_i = 1;
    for (int k = 0; k < NPH * 8 + 20; k++) begin
      @(posedge clk); #2;
      if (cal_done_o) break;
      if (usr_ack_o) leak++;
    end
    chk(cal_done_o, "R8 done", int'(cal_done_o), 1);
    chk(leak == 0, "R3 user blocked", leak, 0);
    chk(ord_bad == 0 && rd_idx == NPH, "R2 sweep order", rd_idx, NPH);
    chk(err_multi_win_o == (e_nw >= 2), "R4 multi window", int'(err_multi_win_o), int'(e_nw >= 2));
    chk(err_multi_lat_o == (e_nl > 2), "R5 multi latency", int'(err_multi_lat_o), int'(e_nl > 2));
    chk(err_no_win_o == (e_nw == 0), "R6 no window", int'(err_no_win_o), int'(e_nw == 0));
    chk(cal_ok_o == e_ok, "R7 ok", int'(cal_ok_o), int'(e_ok));
    chk(int'(best_phase_o) == e_ctr, "R7 centre", int'(best_phase_o), e_ctr);
    chk(int'(best_lat_o) == e_lat, "R7 latency", int'(best_lat_o), e_lat);
    ctl_init_done_i = 0; ctl_ready_i = 0; usr_req_i = 0;
    repeat (6) @(posedge clk);
    #2;
    chk(cal_done_o && cal_ok_o == e_ok && err_multi_win_o == (e_nw >= 2)
        && err_multi_lat_o == (e_nl > 2) && err_no_win_o == (e_nw == 0),
        "R8 sticky", int'(cal_done_o), 1);
    chk(!mem_req_o, "R9 idle user", int'(mem_req_o), 0);
    usr_wr_i = 1'($urandom % 2); usr_req_i = 1;
    #1;
    chk(mem_req_o && mem_wr_o == usr_wr_i, "R9 forward", int'(mem_wr_o), int'(usr_wr_i));
    for (int k = 0; k < 4; k++) begin
      @(posedge clk); #2;
      if (usr_ack_o != mem_ack_i) leak++;
      if (usr_ack_o) seen++;
    end
    chk(leak == 0 && seen > 0, "R9 ack", seen, 1);
    usr_req_i = 0;
  endtask

  task automatic set_win(int s, int l, int lb, int spread);
    for (int p = 0; p < NPH; p++) begin
      tp[p] = (p >= s) && (p < s + l);
      tl[p] = LATW'(lb + (spread > 0 ? int'($urandom % spread) : 0));
    end
  endtask

  initial begin
    void'($urandom(32'd4242));
    set_win(2, 4, 3, 0); run();
    set_win(0, 3, 1, 0); run();
    set_win(5, 3, 2, 0); run();
    set_win(0, 8, 0, 0); run();
    set_win(3, 1, 5, 0); run();
    set_win(0, 0, 0, 0); run();
    set_win(0, 8, 0, 0); tp[4] = 0; run();
    set_win(0, 2, 0, 0); tp[7] = 1; run();
    set_win(1, 6, 0, 0);
    tl[1] = 2; tl[2] = 2; tl[3] = 3; tl[4] = 3; tl[5] = 3; tl[6] = 2; run();
    set_win(1, 6, 0, 0);
    tl[1] = 2; tl[2] = 3; tl[3] = 3; tl[4] = 4; tl[5] = 4; tl[6] = 4; run();
    for (int n = 0; n < 24; n++) begin
      int mode = int'($urandom % 3);
      set_win(int'($urandom % NPH), int'($urandom % (NPH + 1)), int'($urandom % 6), int'($urandom % 4));
      if (mode == 0) for (int p = 0; p < NPH; p++) tp[p] = 1'($urandom % 2);
      if (mode == 2) tp[$urandom % NPH] = 1'($urandom % 2);
      run();
    end
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule